// File: doc/BRIEF.md
# Variable-Length Machine Cycle Clock Generator

This block runs on a single oscillator and splits it into machine cycles for a microcoded processor chip set. Each cycle is a whole number of oscillator periods. A two-bit cycle-type input sets the length of the next cycle. Two active-low ready inputs can add wait periods to the types that go out on a bus: one ready serves external transactions and the other serves internally decoded I/O commands. A falling edge of the main sync clock marks the start of each cycle. The sync clock stays low for the first two periods, when an address or command is on the shared bus. It is high for the rest of the cycle, when data is on the bus, and every wait period lengthens this high phase.

Four clocks are produced. The main sync clock and an identical copy for an interrupt unit always run. A system clock and a precharge clock follow the same cycle timing, but both are held low while pause or bus-hold acknowledge is asserted. On the precharge clock, low means precharge and the rising edge launches the microinstruction field. Every output comes straight from a flop clocked on the rising oscillator edge.

Top module: `mcyc_clkgen`

## Requirements
- R1: Every cycle starts with `sync_n` going low. `sync_n` stays low for the first two oscillator periods of the cycle and is high for the remaining periods.
- R2: Cycle type external (`cyc_kind` = 0) lasts five periods, plus one period for each period in the fifth position where `rdy_n` is high. `irdy_n` has no effect on this type, and `rdy_n` has no effect in any other position.
- R3: Cycle type internal operation (`cyc_kind` = 1) lasts exactly five periods. Cycle type branch (`cyc_kind` = 2) lasts exactly six periods. Neither ready input affects these two types.
- R4: Cycle type internal I/O (`cyc_kind` = 3) lasts six periods, plus one period for each period in the sixth position where `irdy_n` is high, so one wait gives seven. `rdy_n` has no effect on this type.
- R5: `cyc_kind` is captured on the edge that starts a cycle. Changes to it during the cycle do not change that cycle's length.
- R6: `iu_sync_n` is equal to `sync_n` in every period.
- R7: `sys_clk_n` equals `sync_n`, except that it is low in every period that follows an edge where `pause_n` or `hold_ack_n` was sampled low.
- R8: `prechg_n` has the same cycle timing and low-forcing as `sys_clk_n`. It is low for the first two periods of each cycle.
- R9: While the synchronous reset `rst` is high, every output goes low after the next edge and the phase returns to zero. The first cycle after reset has the type that was present on `cyc_kind` during reset, and it is counted from the reset period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc | input | 1 | Oscillator. All state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cyc_kind | input | 2 | Type of the next cycle: 0 external, 1 internal, 2 branch, 3 internal I/O |
| rdy_n | input | 1 | Active-low ready for external transactions |
| irdy_n | input | 1 | Active-low ready for internally decoded I/O |
| pause_n | input | 1 | Active-low pause. Holds the system and precharge clocks low |
| hold_ack_n | input | 1 | Active-low bus-hold acknowledge. Holds the system and precharge clocks low |
| sync_n | output | 1 | Main sync clock. A falling edge starts each cycle |
| iu_sync_n | output | 1 | Copy of `sync_n` for the interrupt unit |
| sys_clk_n | output | 1 | System clock, can be frozen low |
| prechg_n | output | 1 | Precharge clock, can be frozen low |

## Verification
Two things can happen on the same oscillator edge: a stretched cycle ending once its ready is granted, and the capture of the next cycle's type. The bench provokes this with a table of cycles. Each entry withholds ready for a set number of periods while `cyc_kind` already carries the type of the next entry, and briefly carries an unrelated type in the middle of the cycle. The bench measures each cycle's length from one falling edge of `sync_n` to the next and compares it with the length the requirement gives for that entry's type and wait count. A wrong capture or a misplaced ready sample therefore shows up as a wrong length in the following entry.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    typedef enum logic [1:0] {
        CK_EXT    = 2'd0,
        CK_INT    = 2'd1,
        CK_BRANCH = 2'd2,
        CK_IIO    = 2'd3
    } cyc_kind_e;

    // base lengths in oscillator periods
    localparam int unsigned LEN_EXT    = 5;
    localparam int unsigned LEN_INT    = 5;
    localparam int unsigned LEN_BRANCH = 6;
    localparam int unsigned LEN_IIO    = 6;
    localparam int unsigned LEN_MAX    = 6;
    localparam int unsigned PH_W       = $clog2(LEN_MAX);

    typedef logic [PH_W-1:0] phase_t;

    typedef struct packed {
        phase_t    ph;
        cyc_kind_e kind;
    } seq_state_t;

    // index of the final period of a cycle before any wait
    function automatic phase_t last_phase(input cyc_kind_e k);
        case (k)
            CK_EXT:    return phase_t'(LEN_EXT - 1);
            CK_INT:    return phase_t'(LEN_INT - 1);
            CK_BRANCH: return phase_t'(LEN_BRANCH - 1);
            default:   return phase_t'(LEN_IIO - 1);
        endcase
    endfunction

endpackage

// File: rtl/mcyc_phase.sv
module mcyc_phase
    import mcyc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cyc_kind_e kind_in,
    input  logic      rdy_n,
    input  logic      irdy_n,
    output phase_t    ph_nxt
);

    seq_state_t st_q;
    seq_state_t st_d;
    logic       ready_ok;
    logic       at_last;
    logic       end_now;

    always_comb begin
        case (st_q.kind)
            CK_EXT:  ready_ok = !rdy_n;
            CK_IIO:  ready_ok = !irdy_n;
            default: ready_ok = 1'b1;
        endcase
        at_last = (st_q.ph == last_phase(st_q.kind));
        end_now = at_last && ready_ok;
        st_d    = st_q;
        if (end_now) begin
            st_d.ph   = '0;
            st_d.kind = kind_in;
        end else if (!at_last) begin
            st_d.ph = st_q.ph + phase_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ph   <= '0;
            st_q.kind <= kind_in;
        end else begin
            st_q <= st_d;
        end
    end

    assign ph_nxt = rst ? '0 : st_d.ph;

    AST_KIND_HELD: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph != '0) |-> (st_q.kind == $past(st_q.kind))); // R5
    AST_EXT_WAIT: assert property (@(posedge clk) disable iff (rst)
        (st_q.kind == CK_EXT && st_q.ph == last_phase(CK_EXT) && rdy_n)
        |=> (st_q.ph == last_phase(CK_EXT))); // R2
    AST_INT_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        (st_q.kind == CK_INT && st_q.ph == last_phase(CK_INT))
        |=> (st_q.ph == '0)); // R3
    AST_IIO_READY: assert property (@(posedge clk) disable iff (rst)
        (st_q.kind == CK_IIO && st_q.ph == last_phase(CK_IIO) && !irdy_n)
        |=> (st_q.ph == '0)); // R4

endmodule

// File: rtl/mcyc_outs.sv
module mcyc_outs
    import mcyc_pkg::*;
#(
    parameter int unsigned SYNC_LOW = 2,
    parameter int unsigned PRE_LOW  = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_t ph_nxt,
    input  logic   pause_n,
    input  logic   hold_ack_n,
    output logic   sync_n,
    output logic   iu_sync_n,
    output logic   sys_clk_n,
    output logic   prechg_n
);

    localparam phase_t SYNC_EDGE = phase_t'(SYNC_LOW);
    localparam phase_t PRE_EDGE  = phase_t'(PRE_LOW);

    logic run;
    logic sync_hi;
    logic pre_hi;

    always_comb begin
        run     = pause_n & hold_ack_n;
        sync_hi = (ph_nxt >= SYNC_EDGE);
        pre_hi  = (ph_nxt >= PRE_EDGE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_n    <= 1'b0;
            iu_sync_n <= 1'b0;
            sys_clk_n <= 1'b0;
            prechg_n  <= 1'b0;
        end else begin
            sync_n    <= sync_hi;
            iu_sync_n <= sync_hi;
            sys_clk_n <= run & sync_hi;
            prechg_n  <= run & pre_hi;
        end
    end

    AST_IU_COPY: assert property (@(posedge clk) disable iff (rst)
        iu_sync_n == sync_n); // R6
    AST_SYS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!pause_n || !hold_ack_n) |=> !sys_clk_n); // R7
    AST_PRE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!pause_n || !hold_ack_n) |=> !prechg_n); // R8
    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> (!sync_n && !sys_clk_n && !prechg_n && !iu_sync_n)); // R9

endmodule

// File: rtl/mcyc_clkgen.sv
module mcyc_clkgen
    import mcyc_pkg::*;
#(
    parameter int unsigned SYNC_LOW = 2,
    parameter int unsigned PRE_LOW  = 2
) (
    input  logic       osc,
    input  logic       rst,
    input  logic [1:0] cyc_kind,
    input  logic       rdy_n,
    input  logic       irdy_n,
    input  logic       pause_n,
    input  logic       hold_ack_n,
    output logic       sync_n,
    output logic       iu_sync_n,
    output logic       sys_clk_n,
    output logic       prechg_n
);

    phase_t ph_nxt;

    mcyc_phase u_phase (
        .clk     (osc),
        .rst     (rst),
        .kind_in (cyc_kind_e'(cyc_kind)),
        .rdy_n   (rdy_n),
        .irdy_n  (irdy_n),
        .ph_nxt  (ph_nxt)
    );

    mcyc_outs #(
        .SYNC_LOW (SYNC_LOW),
        .PRE_LOW  (PRE_LOW)
    ) u_outs (
        .clk        (osc),
        .rst        (rst),
        .ph_nxt     (ph_nxt),
        .pause_n    (pause_n),
        .hold_ack_n (hold_ack_n),
        .sync_n     (sync_n),
        .iu_sync_n  (iu_sync_n),
        .sys_clk_n  (sys_clk_n),
        .prechg_n   (prechg_n)
    );

endmodule

// File: tb/tb_mcyc_clkgen.sv
module tb_mcyc_clkgen;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] cyc_kind;
    logic       rdy_n, irdy_n, pause_n, hold_ack_n;
    logic       sync_n, iu_sync_n, sys_clk_n, prechg_n;
    int         checks = 0;
    int         fails  = 0;

    always #5 clk = ~clk;

    mcyc_clkgen dut (
        .osc(clk), .rst(rst), .cyc_kind(cyc_kind), .rdy_n(rdy_n),
        .irdy_n(irdy_n), .pause_n(pause_n), .hold_ack_n(hold_ack_n),
        .sync_n(sync_n), .iu_sync_n(iu_sync_n), .sys_clk_n(sys_clk_n),
        .prechg_n(prechg_n)
    );

    // entry = {kind[1:0], waits[2:0]}
    localparam int NV = 10;
    localparam logic [4:0] TBL [NV] = '{
        {2'd0, 3'd0}, {2'd1, 3'd0}, {2'd2, 3'd0}, {2'd3, 3'd0}, {2'd0, 3'd2},
        {2'd3, 3'd1}, {2'd1, 3'd3}, {2'd2, 3'd2}, {2'd0, 3'd1}, {2'd3, 3'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cyc_kind = TBL[0][4:3]; rdy_n = 1'b0; irdy_n = 1'b0;
        pause_n = 1'b1; hold_ack_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 outputs low in reset",
            int'({sync_n, iu_sync_n, sys_clk_n, prechg_n}), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [1:0] k, nk;
            int w, base, exp_len, p, lows, mis_iu, mis_gate;
            logic hi_seen, done;
            k    = TBL[i][4:3];
            w    = int'(TBL[i][2:0]);
            nk   = TBL[(i + 1) % NV][4:3];
            base = (k == 2'd0 || k == 2'd1) ? 5 : 6;
            exp_len = base + ((k == 2'd0 || k == 2'd3) ? w : 0);
            p = 0; lows = 0; mis_iu = 0; mis_gate = 0;
            hi_seen = 1'b0; done = 1'b0;
            while (!done && p < 30) begin
                logic stretch;
                if (!sync_n) lows++; else hi_seen = 1'b1;
                if (iu_sync_n != sync_n) mis_iu++;
                if (sys_clk_n != sync_n || prechg_n != sync_n) mis_gate++;
                stretch = (p < base - 1 + w);
                case (k)
                    2'd0:    begin rdy_n = stretch; irdy_n = 1'b1; end
                    2'd3:    begin irdy_n = stretch; rdy_n = 1'b1; end
                    default: begin rdy_n = stretch; irdy_n = stretch; end
                endcase
                cyc_kind = (p == 2) ? ~k : nk; // R5 mid-cycle change
                step();
                p++;
                done = (!sync_n && hi_seen);
            end
            case (k)
                2'd0:    chk("R2 external cycle length", p, exp_len);
                2'd3:    chk("R4 internal I/O cycle length", p, exp_len);
                default: chk("R3 internal/branch length R5", p, exp_len);
            endcase
            chk("R1 low periods per cycle", lows, 2);
            chk("R6 copy mismatches", mis_iu, 0);
            chk("R7 R8 follow sync when running", mis_gate, 0);
        end

        // R7 R8 freeze by pause, then by hold acknowledge
        rdy_n = 1'b0; irdy_n = 1'b0; cyc_kind = 2'd1;
        for (int s = 0; s < 2; s++) begin
            int highs, bad;
            highs = 0; bad = 0;
            if (s == 0) pause_n = 1'b0; else hold_ack_n = 1'b0;
            for (int j = 0; j < 7; j++) begin
                step();
                if (sync_n) highs++;
                if (sys_clk_n || prechg_n) bad++;
                if (iu_sync_n != sync_n) bad++;
            end
            chk(s == 0 ? "R7 R8 frozen in pause" : "R7 R8 frozen in hold", bad, 0);
            chk("R7 sync kept running while frozen", int'(highs > 0), 1);
            pause_n = 1'b1; hold_ack_n = 1'b1;
            step();
            chk("R7 R8 resume after release",
                int'({sys_clk_n, prechg_n}), int'({sync_n, sync_n}));
        end

        // R9 reset mid-cycle, then first cycle is a branch of six periods
        while (!sync_n) step();
        cyc_kind = 2'd2;
        rst = 1'b1;
        step();
        chk("R9 mid-cycle reset drives all low",
            int'({sync_n, iu_sync_n, sys_clk_n, prechg_n}), 0);
        rst = 1'b0;
        cyc_kind = 2'd0;
        begin
            int p;
            logic hi_seen;
            p = 0; hi_seen = 1'b0;
            while (p < 30 && !(p > 0 && !sync_n && hi_seen)) begin
                if (sync_n) hi_seen = 1'b1;
                step();
                p++;
            end
            chk("R9 first cycle after reset uses captured kind", p, 6);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule